// File: doc/BRIEF.md
# Stop-Exit Clock Source Switcher

This block picks the clock that feeds the CPU around a low-power stop state. In normal running the CPU clock comes from the crystal oscillator. Software may also run the CPU from the internal ring oscillator. A stop request shuts down both oscillators. A wake interrupt then restarts them.

When ring wakeup is enabled, the ring oscillator is enabled in the same cycle that the interrupt arrives, and the CPU restarts on the ring clock at once. Meanwhile a counter measures crystal settling time in crystal cycles. When the count reaches its limit, the CPU is moved to the crystal clock. When ring wakeup is disabled, the CPU clock stays gated until the same count completes.

A stop request that arrives during the settling window aborts the wakeup and returns to stop with both oscillators off. Every change of source passes through a two-flop handshake. Each source is gated on its own falling edge, so the CPU clock never carries a short pulse.

Top module: `wake_clk_switch`

## Requirements
- R1: When stopped with `ring_wake_en`=1, a `wake_irq` puts the CPU on the ring clock, with `src_is_ring`=1, within 6 crystal cycles.
- R2: When stopped with `ring_wake_en`=1, `ring_osc_en` goes to 1 combinationally in the same cycle in which `wake_irq` is high.
- R3: After a ring wakeup, the CPU stays on the ring clock for at least `SETTLE_CYCLES`-2 crystal cycles. It is on the crystal, with `src_is_ring`=0 and `ring_osc_en`=0, by `SETTLE_CYCLES`+10 cycles.
- R4: A stop request during the settling window returns the block to stop. Within 10 cycles both `ring_osc_en` and `xtal_osc_en` are 0 and `cpu_clk` has no edges.
- R5: In normal running, `sw_ring_run`=1 moves the CPU to the ring clock (`src_is_ring`=1, `ring_osc_en`=1). Setting it back to 0 returns the CPU to the crystal (`src_is_ring`=0, `ring_osc_en`=0). `xtal_osc_en` stays 1 in both cases.
- R6: A wake with `ring_wake_en`=0 leaves `ring_osc_en` at 0 and `cpu_clk` without edges until the settling count completes. After that the CPU runs from the crystal.
- R7: At most one source gate is open at any time. No high phase of `cpu_clk` is shorter than the high phase of the source it came from.
- R8: `src_is_ring` reads 1 exactly while the ring gate drives `cpu_clk`. After reset the values are `src_is_ring`=0, `ring_osc_en`=0 and `xtal_osc_en`=1, and the CPU runs on the crystal.
- R9: The settling counter returns to zero on every entry into stop. A wake that follows an aborted wake gets the full settling window again.
- R10: A stop request wins over completion of the settling count when both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal oscillator clock; also the sequencer timebase |
| clk_ring | input | 1 | Internal ring oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to enter the stop state |
| wake_irq | input | 1 | Wake interrupt |
| ring_wake_en | input | 1 | Restart on the ring oscillator after stop |
| sw_ring_run | input | 1 | Software choice of ring clock in normal running |
| cpu_clk | output | 1 | Glitch-free selected CPU clock |
| ring_osc_en | output | 1 | Enable for the ring oscillator |
| xtal_osc_en | output | 1 | Enable for the crystal oscillator |
| src_is_ring | output | 1 | Status: ring oscillator drives the CPU |

## Verification
The case that is hardest to reach from the ports is a second wake that follows an aborted one. Only the timing of that second handover shows whether the counter was cleared on the way into stop. To get there, the bench wakes onto the ring clock, issues a stop ten cycles into the settling window, and confirms that everything is quiet. It then wakes again and checks that the ring source holds for nearly the full window before it hands over. The gated wake, with no ring, is checked by counting `cpu_clk` edges over the window. The absence of glitches is checked by measuring the narrowest high phase of `cpu_clk` over the whole run.

// File: rtl/wake_clk_pkg.sv
`timescale 1ns/1ps
package wake_clk_pkg;

    localparam int NUM_SRC  = 2;
    localparam int SRC_XTAL = 0;
    localparam int SRC_RING = 1;

    typedef enum logic [1:0] {
        SEQ_XTAL  = 2'd0,
        SEQ_STOP  = 2'd1,
        SEQ_WARM  = 2'd2,
        SEQ_GATED = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ring;
        logic xtal;
    } src_pair_t;

    function automatic logic is_settling(seq_state_e s);
        return (s == SEQ_WARM) || (s == SEQ_GATED);
    endfunction

    function automatic src_pair_t want_src(seq_state_e s, logic sw_ring);
        src_pair_t r;
        r.ring = (s == SEQ_WARM) || ((s == SEQ_XTAL) && sw_ring);
        r.xtal = (s == SEQ_XTAL) && !sw_ring;
        return r;
    endfunction

endpackage

// File: rtl/wake_seq.sv
`timescale 1ns/1ps
module wake_seq
    import wake_clk_pkg::*;
#(
    parameter int SETTLE_CYCLES = 65536,
    parameter int CNT_W         = $clog2(SETTLE_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             wake_irq,
    input  logic             ring_wake_en,
    input  logic             sw_ring_run,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output src_pair_t        req_o,
    output src_pair_t        need_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    src_pair_t        req_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_XTAL: if (stop_req) state_d = SEQ_STOP;
            SEQ_STOP: if (wake_irq) state_d = ring_wake_en ? SEQ_WARM : SEQ_GATED;
            SEQ_WARM, SEQ_GATED: begin
                if (stop_req)           state_d = SEQ_STOP;
                else if (cnt_q == LAST) state_d = SEQ_XTAL;
            end
            default: state_d = SEQ_XTAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_XTAL;
            cnt_q   <= '0;
            req_q   <= '{ring: 1'b0, xtal: 1'b1};
        end else begin
            state_q <= state_d;
            if (is_settling(state_q) && (state_d == state_q))
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            req_q <= want_src(state_d, sw_ring_run);
        end
    end

    always_comb begin
        need_o.ring = req_q.ring
                    || ((state_q == SEQ_STOP) && wake_irq && ring_wake_en);
        need_o.xtal = (state_q != SEQ_STOP) || wake_irq;
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign req_o   = req_q;

endmodule

// File: rtl/clk_gate_branch.sv
`timescale 1ns/1ps
module clk_gate_branch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst,
    input  logic req,
    input  logic others_on,
    output logic gate_on
);

    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(negedge clk_src) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], req & ~others_on};
    end

    assign gate_on = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/wake_clk_switch.sv
`timescale 1ns/1ps
module wake_clk_switch
    import wake_clk_pkg::*;
#(
    parameter int SETTLE_CYCLES = 65536,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_xtal,
    input  logic clk_ring,
    input  logic rst,
    input  logic stop_req,
    input  logic wake_irq,
    input  logic ring_wake_en,
    input  logic sw_ring_run,
    output logic cpu_clk,
    output logic ring_osc_en,
    output logic xtal_osc_en,
    output logic src_is_ring
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES);

    seq_state_e           seq_state;
    logic [CNT_W-1:0]     seq_cnt;
    src_pair_t            seq_req, seq_need;
    logic [NUM_SRC-1:0]   src_clk, src_req, src_on;

    wake_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .CNT_W        (CNT_W)
    ) u_seq (
        .clk         (clk_xtal),
        .rst         (rst),
        .stop_req    (stop_req),
        .wake_irq    (wake_irq),
        .ring_wake_en(ring_wake_en),
        .sw_ring_run (sw_ring_run),
        .state_o     (seq_state),
        .cnt_o       (seq_cnt),
        .req_o       (seq_req),
        .need_o      (seq_need)
    );

    always_comb begin
        src_clk = '0;
        src_req = '0;
        src_clk[SRC_XTAL] = clk_xtal;
        src_clk[SRC_RING] = clk_ring;
        src_req[SRC_XTAL] = seq_req.xtal;
        src_req[SRC_RING] = seq_req.ring;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_branch
        localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << g;
        logic others;
        assign others = |(src_on & ~SELF);
        clk_gate_branch #(.SYNC_STAGES(SYNC_STAGES)) u_br (
            .clk_src  (src_clk[g]),
            .rst      (rst),
            .req      (src_req[g]),
            .others_on(others),
            .gate_on  (src_on[g])
        );
    end

    assign cpu_clk     = |(src_clk & src_on);
    assign ring_osc_en = seq_need.ring | src_on[SRC_RING];
    assign xtal_osc_en = seq_need.xtal | src_on[SRC_XTAL];
    assign src_is_ring = src_on[SRC_RING];

endmodule

// File: rtl/wake_clk_switch_chk.sv
`timescale 1ns/1ps
module wake_clk_switch_chk
    import wake_clk_pkg::*;
#(
    parameter int SETTLE_CYCLES = 65536,
    parameter int CNT_W         = $clog2(SETTLE_CYCLES)
) (
    input logic             clk_xtal,
    input logic             rst,
    input logic             stop_req,
    input logic             wake_irq,
    input logic             ring_wake_en,
    input seq_state_e       seq_state,
    input logic [CNT_W-1:0] seq_cnt,
    input src_pair_t        seq_req,
    input logic [1:0]       src_on
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    assert_gate_exclusive_R7: assert property (@(posedge clk_xtal) disable iff (rst)
        $onehot0(src_on));

    assert_wake_to_ring_R1: assert property (@(posedge clk_xtal) disable iff (rst)
        (seq_state == SEQ_STOP && wake_irq && ring_wake_en) |=> (seq_state == SEQ_WARM));

    assert_abort_to_stop_R4: assert property (@(posedge clk_xtal) disable iff (rst)
        (is_settling(seq_state) && stop_req) |=> (seq_state == SEQ_STOP));

    assert_handover_R3: assert property (@(posedge clk_xtal) disable iff (rst)
        (seq_state == SEQ_WARM && seq_cnt == LAST && !stop_req) |=> (seq_state == SEQ_XTAL));

    assert_cnt_cleared_R9: assert property (@(posedge clk_xtal) disable iff (rst)
        (seq_state == SEQ_STOP) |=> (seq_cnt == '0));

    assert_stop_priority_R10: assert property (@(posedge clk_xtal) disable iff (rst)
        (seq_state == SEQ_GATED && seq_cnt == LAST && stop_req) |=> (seq_state == SEQ_STOP));

    assert_gated_no_req_R6: assert property (@(posedge clk_xtal) disable iff (rst)
        (seq_state == SEQ_GATED) |-> (!seq_req.ring && !seq_req.xtal));

endmodule

bind wake_clk_switch wake_clk_switch_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk_xtal    (clk_xtal),
    .rst         (rst),
    .stop_req    (stop_req),
    .wake_irq    (wake_irq),
    .ring_wake_en(ring_wake_en),
    .seq_state   (seq_state),
    .seq_cnt     (seq_cnt),
    .seq_req     (seq_req),
    .src_on      (src_on)
);

// File: tb/wake_clk_switch_tb.sv
`timescale 1ns/1ps
module wake_clk_switch_tb;

    localparam int SETTLE = 32;

    logic clk_xtal = 1'b0, clk_ring = 1'b0, rst = 1'b1;
    logic stop_req = 1'b0, wake_irq = 1'b0, ring_wake_en = 1'b0, sw_ring_run = 1'b0;
    logic cpu_clk, ring_osc_en, xtal_osc_en, src_is_ring;

    int n_chk = 0, n_err = 0, clk_edges = 0, e0 = 0;
    realtime t_rise = 0.0, min_high = 100.0;

    always #2.5 clk_xtal = ~clk_xtal;
    always #1.6 clk_ring = ~clk_ring;

    always @(posedge cpu_clk) begin
        clk_edges++;
        t_rise = $realtime;
    end
    always @(negedge cpu_clk) if (!rst && ($realtime - t_rise) < min_high) min_high = $realtime - t_rise;

    wake_clk_switch #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk_xtal(clk_xtal), .clk_ring(clk_ring), .rst(rst),
        .stop_req(stop_req), .wake_irq(wake_irq), .ring_wake_en(ring_wake_en),
        .sw_ring_run(sw_ring_run), .cpu_clk(cpu_clk), .ring_osc_en(ring_osc_en),
        .xtal_osc_en(xtal_osc_en), .src_is_ring(src_is_ring)
    );

    // row: {ring_wake_en, sw_ring_run, exp src_is_ring, exp ring_osc_en, exp xtal_osc_en}
    localparam logic [4:0] VEC [6] = '{
        5'b00001, 5'b01111, 5'b11111, 5'b10001, 5'b01111, 5'b00001
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk_xtal);
        #1;
    endtask

    task automatic do_stop();
        stop_req = 1'b1;
        tick(1);
        stop_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(8);
        // R8 reset state
        chk("R8 src after reset", int'(src_is_ring), 0);
        chk("R8 ring_en after reset", int'(ring_osc_en), 0);
        chk("R8 xtal_en after reset", int'(xtal_osc_en), 1);
        e0 = clk_edges;
        tick(4);
        chk("R8 crystal drives cpu", int'(clk_edges > e0), 1);

        // R5 software ring selection in normal running
        foreach (VEC[i]) begin
            ring_wake_en = VEC[i][4];
            sw_ring_run  = VEC[i][3];
            tick(10);
            chk($sformatf("R5 row%0d src", i), int'(src_is_ring), int'(VEC[i][2]));
            chk($sformatf("R5 row%0d ring_en", i), int'(ring_osc_en), int'(VEC[i][1]));
            chk($sformatf("R5 row%0d xtal_en", i), int'(xtal_osc_en), int'(VEC[i][0]));
        end

        // R1 R2 R3 ring wakeup and handover
        ring_wake_en = 1'b1;
        do_stop();
        tick(10);
        chk("R4 stop ring_en", int'(ring_osc_en), 0);
        chk("R4 stop xtal_en", int'(xtal_osc_en), 0);
        wake_irq = 1'b1;
        #0.5;
        chk("R2 ring_en same cycle", int'(ring_osc_en), 1);
        tick(1);
        wake_irq = 1'b0;
        tick(6);
        chk("R1 on ring after wake", int'(src_is_ring), 1);
        e0 = clk_edges;
        tick(SETTLE - 8);
        chk("R3 still ring near end", int'(src_is_ring), 1);
        chk("R1 ring clock runs", int'(clk_edges > e0), 1);
        tick(12);
        chk("R3 handed to crystal", int'(src_is_ring), 0);
        chk("R3 ring_en released", int'(ring_osc_en), 0);
        chk("R3 xtal_en on", int'(xtal_osc_en), 1);

        // R4 abort during warmup, then R9 full window on next wake
        do_stop();
        tick(10);
        wake_irq = 1'b1;
        tick(1);
        wake_irq = 1'b0;
        tick(10);
        chk("R4 ring before abort", int'(src_is_ring), 1);
        do_stop();
        tick(10);
        chk("R4 abort ring_en", int'(ring_osc_en), 0);
        chk("R4 abort xtal_en", int'(xtal_osc_en), 0);
        chk("R4 abort src", int'(src_is_ring), 0);
        e0 = clk_edges;
        tick(10);
        chk("R4 cpu_clk idle", clk_edges - e0, 0);
        wake_irq = 1'b1;
        tick(1);
        wake_irq = 1'b0;
        tick(SETTLE - 2);
        chk("R9 full window after abort", int'(src_is_ring), 1);
        tick(12);
        chk("R9 handover after full window", int'(src_is_ring), 0);

        // R6 wake without ring: gated until count completes
        ring_wake_en = 1'b0;
        do_stop();
        tick(10);
        wake_irq = 1'b1;
        #0.5;
        chk("R6 ring_en stays low", int'(ring_osc_en), 0);
        tick(1);
        wake_irq = 1'b0;
        tick(2);
        e0 = clk_edges;
        tick(SETTLE - 6);
        chk("R6 cpu_clk gated", clk_edges - e0, 0);
        chk("R6 ring_en low in window", int'(ring_osc_en), 0);
        tick(14);
        e0 = clk_edges;
        tick(5);
        chk("R6 crystal after count", int'(clk_edges > e0), 1);
        chk("R6 src crystal", int'(src_is_ring), 0);

        // R5 stop while software ring runs halts both oscillators
        sw_ring_run = 1'b1;
        tick(10);
        chk("R5 sw ring before stop", int'(src_is_ring), 1);
        do_stop();
        tick(10);
        chk("R4 stop from sw ring ring_en", int'(ring_osc_en), 0);
        chk("R4 stop from sw ring xtal_en", int'(xtal_osc_en), 0);

        // R7 no glitch: narrowest high phase at least the ring half period
        chk("R7 no short high pulse", int'(min_high >= 1.55), 1);

        finish_run();
    end

endmodule